// File: doc/BRIEF.md
# Sample Clock Divider with Phase Slip

This block derives an output data clock from a fast sample clock by dividing it by one, two or four. A 3-bit control register picks the ratio. When it holds its reset value, the ratio comes from an external select, which an upstream pad decoder has already reduced to a 2-bit code. Writing an unsupported code leaves the running ratio untouched and raises a sticky error flag.

A phase-slip command moves the divided clock's rising edge one sample-clock period earlier. Boards that carry several converters use it to line up their data clocks. Software arms the command by writing 0 and then 1 to bit 0 of the slip register, and the slip fires on that 0-to-1 change. Slips accumulate. In divide-by-1 there is no phase to move, so the command is dropped.

A soft reset clears only the slip register. It leaves the ratio register and the running counter alone. A hard reset clears everything.

Top module: `sample_clock_divider`

## Requirements
- R1: Ratio register code 3'b001 makes the output clock follow the sample clock, with a rising edge every input period.
- R2: Code 3'b010 divides by two, so the output is high for one input period and low for one.
- R3: Code 3'b100 divides by four, so the output is high for two input periods and low for two.
- R4: Code 3'b000 hands the ratio to the external select, where 2'd0 gives divide by 1, 2'd1 gives divide by 2, 2'd2 gives divide by 4 and 2'd3 gives divide by 1. A change of the select takes effect while in this mode.
- R5: Writing any other code leaves the running ratio unchanged, and the error flag reads 1 one cycle after the write. The flag stays set until a legal code is written, and then it reads 0 one cycle later.
- R6: A 0-to-1 change of slip-register bit 0 moves every later rising edge of the output one input period earlier.
- R7: Writing 1 to the slip register while its bit 0 is already 1 causes no slip.
- R8: Slips accumulate. In divide by 2, one slip shifts the edges by half an output period and two slips restore the original grid. In divide by 4, two slips shift them by two input periods.
- R9: In divide by 1 a slip command is ignored, and the output keeps the input's period and half-period high time.
- R10: A soft reset leaves the ratio register and the output phase unchanged and clears slip-register bit 0, so a lone write of 1 afterwards triggers a slip.
- R11: A change of ratio restarts the divider. While dividing by 2 or 4, no output high or low phase is shorter than one input period, even across changes.
- R12: After a hard reset the ratio register is 3'b000, the error flag is 0 and the divider counter starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Hard reset, active low |
| softRst | input | 1 | Soft reset, clears only the slip register |
| divWe | input | 1 | Write strobe for the ratio register |
| divData | input | 3 | Ratio code to write |
| slipWe | input | 1 | Write strobe for the slip register |
| slipData | input | 1 | Value for slip-register bit 0 |
| extSel | input | 2 | Decoded external ratio select |
| outClk | output | 1 | Divided output data clock |
| errFlag | output | 1 | Sticky flag for an unsupported ratio code |

## Verification
The bench times the rising edges of the output clock. It uses them to tell the three ratios apart, through each register code and through each pin code, and to tell a changed ratio from one that an illegal write left alone. Slip commands are compared as edge offsets modulo the output period against a grid captured before the command. This separates a true one-period advance from no slip, from a double slip and from a slip taken on a repeated write of 1. A pulse-width monitor, run while the ratio is toggled at short intervals, tells a clean restart from one that leaves runt pulses. Soft and hard resets are compared by whether the ratio and phase survive.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int CODE_W = 3;
  localparam int SEL_W  = 2;

  typedef enum logic [1:0] {
    DIV_BY1 = 2'd0,
    DIV_BY2 = 2'd1,
    DIV_BY4 = 2'd2
  } divKindT;

  typedef struct packed {
    logic    restart;
    logic    slip;
    divKindT kind;
  } divStrobeT;

  function automatic logic codeLegal(input logic [CODE_W-1:0] code);
    return (code == 3'b000) || (code == 3'b001) || (code == 3'b010) || (code == 3'b100);
  endfunction
endpackage

// File: rtl/div_ctrl.sv
`timescale 1ns/1ps
module div_ctrl
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              divWe,
  input  logic [CODE_W-1:0] divData,
  input  logic              slipWe,
  input  logic              slipData,
  input  logic [SEL_W-1:0]  extSel,
  output divStrobeT         strobes,
  output logic [CODE_W-1:0] divCode,
  output logic              errFlag
);
  divKindT kindNow;
  divKindT kindPrev;
  logic    slipBit;
  logic    slipPrev;
  logic    restartNow;

  // Ratio register and sticky error: hard reset only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCode <= '0;
      errFlag <= 1'b0;
    end else if (divWe) begin
      if (codeLegal(divData)) begin
        divCode <= divData;
        errFlag <= 1'b0;
      end else begin
        errFlag <= 1'b1;
      end
    end
  end

  // Effective ratio: register code, or the external select at code 000
  always_comb begin
    case (divCode)
      3'b001:  kindNow = DIV_BY1;
      3'b010:  kindNow = DIV_BY2;
      3'b100:  kindNow = DIV_BY4;
      default: begin
        case (extSel)
          2'd1:    kindNow = DIV_BY2;
          2'd2:    kindNow = DIV_BY4;
          default: kindNow = DIV_BY1;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) kindPrev <= DIV_BY1;
    else       kindPrev <= kindNow;
  end

  assign restartNow = (kindNow != kindPrev);

  // Slip register: soft reset clears the bit, edge history is hard reset only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        slipBit <= 1'b0;
    else if (softRst) slipBit <= 1'b0;
    else if (slipWe)  slipBit <= slipData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slipPrev <= 1'b0;
    else       slipPrev <= slipBit;
  end

  always_comb begin
    strobes.kind    = kindNow;
    strobes.restart = restartNow;
    strobes.slip    = slipBit && !slipPrev && (kindNow != DIV_BY1) && !restartNow;
  end
endmodule

// File: rtl/div_path.sv
`timescale 1ns/1ps
module div_path
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  divStrobeT strobes,
  output logic      outClk
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] cntMask;
  logic [CNT_W-1:0] halfVal;
  logic             phaseReg;

  always_comb begin
    case (strobes.kind)
      DIV_BY2: begin cntMask = CNT_W'(1); halfVal = CNT_W'(1); end
      DIV_BY4: begin cntMask = CNT_W'(3); halfVal = CNT_W'(2); end
      default: begin cntMask = '0;        halfVal = CNT_W'(1); end
    endcase
  end

  // A slip skips one count, so the wrap (rising edge) comes one cycle earlier
  always_comb begin
    if (strobes.restart)   cntNext = '0;
    else if (strobes.slip) cntNext = (cnt + TWO) & cntMask;
    else                   cntNext = (cnt + ONE) & cntMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      phaseReg <= 1'b1;
    end else begin
      cnt      <= cntNext;
      phaseReg <= (cntNext < halfVal);
    end
  end

  assign outClk = (strobes.kind == DIV_BY1) ? clk : phaseReg;
endmodule

// File: rtl/sample_clock_divider.sv
`timescale 1ns/1ps
module sample_clock_divider
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              divWe,
  input  logic [CODE_W-1:0] divData,
  input  logic              slipWe,
  input  logic              slipData,
  input  logic [SEL_W-1:0]  extSel,
  output logic              outClk,
  output logic              errFlag
);
  divStrobeT         strobes;
  logic [CODE_W-1:0] divCode;

  div_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst),
    .divWe(divWe), .divData(divData),
    .slipWe(slipWe), .slipData(slipData), .extSel(extSel),
    .strobes(strobes), .divCode(divCode), .errFlag(errFlag)
  );

  div_path #(.CNT_W(CNT_W)) i_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .outClk(outClk)
  );
endmodule

// File: rtl/sample_clock_divider_chk.sv
`timescale 1ns/1ps
module sample_clock_divider_chk
  import clkdiv_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              softRst,
  input logic              divWe,
  input logic [CODE_W-1:0] divData,
  input logic              errFlag,
  input logic [CODE_W-1:0] divCode,
  input divStrobeT         strobes
);
  assert_err_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    (divWe && !codeLegal(divData)) |=> errFlag);

  assert_err_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (divWe && codeLegal(divData)) |=> !errFlag);

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    !divWe |=> $stable(errFlag));

  assert_code_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    (divWe && !codeLegal(divData)) |=> $stable(divCode));

  assert_soft_keeps_code_R10: assert property (@(posedge clk) disable iff (!rstN)
    (softRst && !divWe) |=> $stable(divCode));

  assert_no_slip_div1_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.slip |-> (strobes.kind != DIV_BY1));

  assert_restart_on_change_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.kind != $past(strobes.kind)) |-> strobes.restart);

  assert_slip_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.slip, strobes.restart}));
endmodule

bind sample_clock_divider sample_clock_divider_chk i_chk (
  .clk(clk), .rstN(rstN), .softRst(softRst), .divWe(divWe), .divData(divData),
  .errFlag(errFlag), .divCode(divCode), .strobes(strobes)
);

// File: tb/test_sample_clock_divider.sv
`timescale 1ns/1ps
module test_sample_clock_divider;
  localparam time PER = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       softRst = 1'b0;
  logic       divWe = 1'b0;
  logic [2:0] divData = 3'b000;
  logic       slipWe = 1'b0;
  logic       slipData = 1'b0;
  logic [1:0] extSel = 2'd0;
  logic       outClk;
  logic       errFlag;

  int  vectors = 0;
  int  misses = 0;
  time lastRise = 0;
  time prevRise = 0;
  time lastEdge = 0;
  time minW = 1000;
  bit  monOn = 1'b0;
  time t0;

  sample_clock_divider i_sample_clock_divider (
    .clk(clk), .rstN(rstN), .softRst(softRst), .divWe(divWe), .divData(divData),
    .slipWe(slipWe), .slipData(slipData), .extSel(extSel),
    .outClk(outClk), .errFlag(errFlag)
  );

  always #(PER/2) clk = ~clk;

  always @(posedge outClk) begin
    prevRise = lastRise;
    lastRise = $time;
  end

  always @(outClk) begin
    if (monOn && ($time - lastEdge) < minW) minW = $time - lastEdge;
    lastEdge = $time;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeDiv(input logic [2:0] code);
    divWe = 1'b1; divData = code;
    cyc(1);
    divWe = 1'b0;
  endtask

  task automatic writeSlip(input logic b);
    slipWe = 1'b1; slipData = b;
    cyc(1);
    slipWe = 1'b0;
  endtask

  task automatic doSlip();
    writeSlip(1'b0);
    writeSlip(1'b1);
  endtask

  task automatic checkPeriod(input string req, input time expPer);
    cyc(20);
    check((lastRise - prevRise) == expPer, req, longint'(lastRise - prevRise), longint'(expPer));
  endtask

  task automatic checkShift(input string req, input time outPer, input time expShift);
    cyc(16);
    check(((lastRise - t0) % outPer) == expShift, req,
          longint'((lastRise - t0) % outPer), longint'(expShift));
  endtask

  task automatic checkMinWidth(input string req, input time expW);
    cyc(4);
    minW = 1000; monOn = 1'b1;
    cyc(24);
    monOn = 1'b0;
    check(minW == expW, req, longint'(minW), longint'(expW));
  endtask

  task automatic testReset();
    rstN = 1'b0; cyc(3); rstN = 1'b1; cyc(1);
    check(errFlag == 1'b0, "R12 err after reset", errFlag, 0);
    checkPeriod("R12 pin divide-by-1 after reset", PER);
  endtask

  task automatic testPin();
    extSel = 2'd1; checkPeriod("R4 pin sel 1", 2*PER);
    extSel = 2'd2; checkPeriod("R4 pin sel 2", 4*PER);
    extSel = 2'd3; checkPeriod("R4 pin sel 3", PER);
    extSel = 2'd0;
  endtask

  task automatic testRegCodes();
    extSel = 2'd2;
    writeDiv(3'b001); checkPeriod("R1 code 001", PER);
    writeDiv(3'b010); checkPeriod("R2 code 010", 2*PER);
    checkMinWidth("R2 half width", PER);
    writeDiv(3'b100); checkPeriod("R3 code 100", 4*PER);
    checkMinWidth("R3 half width", 2*PER);
    extSel = 2'd0;
  endtask

  task automatic testIllegal();
    writeDiv(3'b011);
    check(errFlag == 1'b1, "R5 err set", errFlag, 1);
    checkPeriod("R5 ratio kept", 4*PER);
    writeDiv(3'b111);
    check(errFlag == 1'b1, "R5 err still set", errFlag, 1);
    cyc(5);
    check(errFlag == 1'b1, "R5 err sticky", errFlag, 1);
    writeDiv(3'b010);
    check(errFlag == 1'b0, "R5 err cleared", errFlag, 0);
    checkPeriod("R5 legal code applied", 2*PER);
  endtask

  task automatic testSlip();
    writeDiv(3'b100); cyc(12);
    t0 = lastRise; doSlip();
    checkShift("R6 one slip in div4", 4*PER, 3*PER);
    t0 = lastRise; writeSlip(1'b1);
    checkShift("R7 repeated 1 no slip", 4*PER, 0);
    t0 = lastRise; doSlip(); doSlip();
    checkShift("R8 two slips div4", 4*PER, 2*PER);
    writeDiv(3'b010); cyc(12);
    t0 = lastRise; doSlip();
    checkShift("R8 one slip div2", 2*PER, PER);
    doSlip();
    checkShift("R8 two slips div2", 2*PER, 0);
  endtask

  task automatic testSlipDiv1();
    writeDiv(3'b001); cyc(6);
    doSlip();
    checkPeriod("R9 div1 period after slip", PER);
    checkMinWidth("R9 div1 width after slip", PER/2);
  endtask

  task automatic testSoftReset();
    writeDiv(3'b100); cyc(12);
    t0 = lastRise;
    softRst = 1'b1; cyc(1); softRst = 1'b0;
    checkPeriod("R10 ratio after soft reset", 4*PER);
    checkShift("R10 phase after soft reset", 4*PER, 0);
    t0 = lastRise; writeSlip(1'b1);
    checkShift("R10 slip bit cleared", 4*PER, 3*PER);
  endtask

  task automatic testRestart();
    cyc(8);
    minW = 1000; monOn = 1'b1;
    for (int i = 0; i < 6; i++) begin
      writeDiv(i[0] ? 3'b100 : 3'b010);
      cyc(1 + (i % 3));
    end
    cyc(20);
    monOn = 1'b0;
    check(minW >= PER, "R11 no runt pulse", longint'(minW), longint'(PER));
    checkPeriod("R11 final ratio", 4*PER);
  endtask

  task automatic testHardReset();
    writeDiv(3'b110);
    check(errFlag == 1'b1, "R12 err before reset", errFlag, 1);
    extSel = 2'd0;
    rstN = 1'b0; cyc(2); rstN = 1'b1; cyc(1);
    check(errFlag == 1'b0, "R12 err cleared by hard reset", errFlag, 0);
    checkPeriod("R12 code back to pin control", PER);
    extSel = 2'd1;
    checkPeriod("R12 pin control active", 2*PER);
  endtask

  initial begin
    #(PER * 150000);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    cyc(1);
    testReset();
    testPin();
    testRegCodes();
    testIllegal();
    testSlip();
    testSlipDiv1();
    testSoftReset();
    testRestart();
    testHardReset();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule